// File: doc/BRIEF.md
# DMA Channel Shadow Address Controller

This block holds the address state of one DMA channel: the active source address, the active destination address, a shadow address and a checksum register. A four-bit mode input decides what a software register write does and how the channel gets its next control set between transactions. In the buffered modes a write is parked in the shadow register and moved into the active register when the next transaction starts. The double-buffering modes exchange the active and shadow addresses on a software request, and the automatic variants also do so on transaction completion. The linked-list modes fetch a new control set from memory when a transaction finishes.

Linked-list reload is run by a small state machine. Its states are IDLE (no fetch in progress), FETCH (the fetch request is raised and control-set words are accepted), APPLY (the staged set is checked and written into the registers) and HALT (the checksum check failed and the channel waits for software). The transitions are:

- *fetch-launch*: IDLE to FETCH, on a done pulse in a linked-list mode.
- *stream-end*: FETCH to APPLY, on the last expected word.
- *apply-ok*: APPLY to IDLE, after the commit.
- *apply-reject*: APPLY to HALT, on a checksum mismatch in guarded mode.
- *sw-release*: HALT to IDLE, on the error-clear input.

Data movement, checksum computation and pattern detection happen elsewhere. Their results reach this block as inputs.

Top module: `dma_shadow_ctl`

## Requirements
- R1: The mode input is decoded as follows: 0 = direct, 1 and 3 = source buffered, 2 and 4 = destination buffered, 5 = source double buffer with software swap, 6 = source double buffer with hardware and software swap, 7 = destination double buffer with software swap, 8 = destination double buffer with hardware and software swap, 9 = plain linked list, 10 = accumulated linked list, 11 = checksum-guarded linked list, 12 = conditional linked list. Values 13 to 15 act as direct. In direct mode, a write with wr_sel 0 (source) or 1 (destination) changes that register on the next clock edge.
- R2: In source-buffered mode, a source write goes to the shadow register and sets pend. A start pulse while pend is set copies the shadow into the source address and clears pend. A start pulse with pend clear changes nothing.
- R3: In destination-buffered mode, a destination write is buffered the same way and moves into the destination address on start. A source write in this mode goes straight to the source address.
- R4: A second buffered write before start replaces the shadow value. A buffered write in the same cycle as start becomes the new pending value, and pend stays set.
- R5: In the software-swap double-buffer modes, sw_switch exchanges the active register (source for mode 5, destination for mode 7) with the shadow. A done pulse does not swap in these modes.
- R6: In the hardware-and-software variants (modes 6 and 8), a done pulse also swaps. When done and sw_switch arrive in the same cycle, exactly one swap happens.
- R7: In modes 9 to 12, a done pulse in IDLE raises ll_req on the next edge. ll_ptr then carries the shadow register, latched at the done pulse. Words arrive in order on ll_valid: word 0 is the source address, word 1 the destination, word 2 the shadow and word 6 the checksum. ll_req falls after the last word.
- R8: Plain linked-list mode takes 8 words. One cycle after the last word, it overwrites the source, destination, shadow and checksum registers.
- R9: Accumulated linked-list mode takes 6 words and overwrites the source, destination and shadow registers. The checksum register keeps its value.
- R10: Guarded linked-list mode takes 8 words. If crc_in equals loaded word 6, the set is committed. Otherwise nothing is committed, err goes high and stays high until err_clr.
- R11: Conditional linked-list mode takes 8 words. If pat_hit is high at the done pulse, ll_ptr is the checksum register; if pat_hit is low, ll_ptr is the shadow register.
- R12: After reset, all four registers are zero, and pend, ll_req and err are low.
- R13: A done pulse during FETCH or HALT is ignored: ll_ptr holds its value and no new fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Channel reload mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 shadow, 3 checksum |
| wr_data | input | DW | Write data |
| xfer_start | input | 1 | Transaction start pulse |
| xfer_done | input | 1 | Transaction completion pulse |
| sw_switch | input | 1 | Software buffer swap request |
| pat_hit | input | 1 | Pattern-detection condition |
| crc_in | input | DW | Running checksum of the channel |
| ll_valid | input | 1 | Control-set word valid |
| ll_word | input | DW | Control-set word |
| err_clr | input | 1 | Clears the checksum error and releases HALT |
| src_addr | output | DW | Active source address |
| dst_addr | output | DW | Active destination address |
| shd_addr | output | DW | Shadow address register |
| sum_reg | output | DW | Checksum register |
| ll_req | output | 1 | Control-set fetch request |
| ll_ptr | output | DW | Address of the control set to fetch |
| pend | output | 1 | Buffered write awaiting transfer |
| err | output | 1 | Sticky checksum mismatch flag |

## Verification
The assertions assume three things about the inputs. The mode input stays constant from a done pulse until the channel is back in IDLE. ll_valid is raised only while ll_req is high. crc_in is stable during the APPLY cycle. The stimulus changes mode only between reload sequences and drives exactly the expected number of words, one per cycle, each inside an ll_req window. It also holds crc_in for the whole guarded sequence.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

    // control-set word positions decoded by the staging logic
    localparam int IDX_SRC = 0;
    localparam int IDX_DST = 1;
    localparam int IDX_SHD = 2;
    localparam int IDX_SUM = 6;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_SHD = 2'd2,
        SEL_SUM = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2,
        ST_HALT  = 2'd3
    } st_e;

    typedef struct packed {
        logic direct;
        logic src_buf;
        logic dst_buf;
        logic src_dbl;
        logic dst_dbl;
        logic hw_sw;
        logic ll;
        logic ll_acc;
        logic ll_safe;
        logic ll_cond;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] m);
        mode_dec_t d;
        d = '0;
        case (m)
            4'd1, 4'd3: d.src_buf = 1'b1;
            4'd2, 4'd4: d.dst_buf = 1'b1;
            4'd5:       d.src_dbl = 1'b1;
            4'd6:       begin d.src_dbl = 1'b1; d.hw_sw = 1'b1; end
            4'd7:       d.dst_dbl = 1'b1;
            4'd8:       begin d.dst_dbl = 1'b1; d.hw_sw = 1'b1; end
            4'd9:       d.ll = 1'b1;
            4'd10:      begin d.ll = 1'b1; d.ll_acc = 1'b1; end
            4'd11:      begin d.ll = 1'b1; d.ll_safe = 1'b1; end
            4'd12:      begin d.ll = 1'b1; d.ll_cond = 1'b1; end
            default:    d.direct = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dsh_fsm.sv
module dsh_fsm
    import dsh_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_mode,
    input  logic          safe_mode,
    input  logic          cond_mode,
    input  logic          done,
    input  logic          pat_hit,
    input  logic [DW-1:0] shd,
    input  logic [DW-1:0] sum,
    input  logic [DW-1:0] stg_sum,
    input  logic [DW-1:0] crc_in,
    input  logic          last,
    input  logic          err_clr,
    output logic          ll_req,
    output logic [DW-1:0] ll_ptr,
    output logic          commit,
    output logic          err
);

    st_e           state_q, state_d;
    logic [DW-1:0] ptr_q;
    logic          sum_ok;

    assign sum_ok = (crc_in == stg_sum);
    assign ll_ptr = ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ll_mode && done) state_d = ST_FETCH;
            ST_FETCH: if (last) state_d = ST_APPLY;
            ST_APPLY: state_d = (safe_mode && !sum_ok) ? ST_HALT : ST_IDLE;
            ST_HALT:  if (err_clr) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ll_req = 1'b0;
        commit = 1'b0;
        err    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: ll_req = 1'b1;
            ST_APPLY: commit = !(safe_mode && !sum_ok);
            ST_HALT:  err = 1'b1;
            default:  ;
        endcase
    end

    // next-set pointer, captured when a fetch is launched
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (state_q == ST_IDLE && ll_mode && done)
            ptr_q <= (cond_mode && pat_hit) ? sum : shd;
    end

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(safe_mode) && !$past(sum_ok)));

    p_ptr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_req && $past(ll_req)) |-> $stable(ll_ptr));

    p_req_not_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ll_req |-> !err);

endmodule

// File: rtl/dsh_ll_stage.sv
module dsh_ll_stage
    import dsh_pkg::*;
#(
    parameter int DW        = 32,
    parameter int SET_WORDS = 8,
    parameter int ACC_WORDS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetching,
    input  logic          acc_mode,
    input  logic          ll_valid,
    input  logic [DW-1:0] ll_word,
    output logic          last,
    output logic [DW-1:0] stg_src,
    output logic [DW-1:0] stg_dst,
    output logic [DW-1:0] stg_shd,
    output logic [DW-1:0] stg_sum
);

    localparam int CNT_W = (SET_WORDS > 1) ? $clog2(SET_WORDS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             take;

    assign lim_m1 = acc_mode ? CNT_W'(ACC_WORDS - 1) : CNT_W'(SET_WORDS - 1);
    assign take   = fetching && ll_valid;
    assign last   = take && (cnt_q == lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || !fetching) cnt_q <= '0;
        else if (ll_valid)       cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_src <= '0;
            stg_dst <= '0;
            stg_shd <= '0;
            stg_sum <= '0;
        end else if (take) begin
            if (cnt_q == CNT_W'(IDX_SRC)) stg_src <= ll_word;
            if (cnt_q == CNT_W'(IDX_DST)) stg_dst <= ll_word;
            if (cnt_q == CNT_W'(IDX_SHD)) stg_shd <= ll_word;
            if (cnt_q == CNT_W'(IDX_SUM)) stg_sum <= ll_word;
        end
    end

    p_last_ends_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !fetching);

endmodule

// File: rtl/dsh_addr_regs.sv
module dsh_addr_regs
    import dsh_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          direct,
    input  logic          src_buf,
    input  logic          dst_buf,
    input  logic          src_dbl,
    input  logic          dst_dbl,
    input  logic          hw_sw,
    input  logic          keep_sum,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          start,
    input  logic          done,
    input  logic          sw,
    input  logic          commit,
    input  logic [DW-1:0] stg_src,
    input  logic [DW-1:0] stg_dst,
    input  logic [DW-1:0] stg_shd,
    input  logic [DW-1:0] stg_sum,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] dst_q,
    output logic [DW-1:0] shd_q,
    output logic [DW-1:0] sum_q,
    output logic          pend_q
);

    logic [DW-1:0] n_src, n_dst, n_shd, n_sum;
    logic          n_pend;
    logic          swap;

    assign swap = sw || (hw_sw && done);

    always_comb begin
        n_src  = src_q;
        n_dst  = dst_q;
        n_shd  = shd_q;
        n_sum  = sum_q;
        n_pend = pend_q;
        // buffered transfer at transaction start
        if (start && pend_q) begin
            if (src_buf)      n_src = shd_q;
            else if (dst_buf) n_dst = shd_q;
            n_pend = 1'b0;
        end
        // double-buffer exchange, one per cycle at most
        if (swap) begin
            if (src_dbl) begin
                n_src = shd_q;
                n_shd = src_q;
            end else if (dst_dbl) begin
                n_dst = shd_q;
                n_shd = dst_q;
            end
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_SRC: if (src_buf) begin n_shd = wr_data; n_pend = 1'b1; end
                         else n_src = wr_data;
                SEL_DST: if (dst_buf) begin n_shd = wr_data; n_pend = 1'b1; end
                         else n_dst = wr_data;
                SEL_SHD: n_shd = wr_data;
                default: n_sum = wr_data;
            endcase
        end
        // linked-list commit overrides everything else
        if (commit) begin
            n_src = stg_src;
            n_dst = stg_dst;
            n_shd = stg_shd;
            if (!keep_sum) n_sum = stg_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            shd_q  <= '0;
            sum_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            src_q  <= n_src;
            dst_q  <= n_dst;
            shd_q  <= n_shd;
            sum_q  <= n_sum;
            pend_q <= n_pend;
        end
    end

    p_direct_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && wr_en && wr_sel == SEL_SRC && !commit) |=> src_q == $past(wr_data));

    p_buf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_buf && pend_q && start && !wr_en && !commit) |=> src_q == $past(shd_q));

    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(start));

    p_single_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_dbl && sw && !wr_en && !commit) |=> (src_q == $past(shd_q) && shd_q == $past(src_q)));

endmodule

// File: rtl/dma_shadow_ctl.sv
module dma_shadow_ctl
    import dsh_pkg::*;
#(
    parameter int DW        = 32,
    parameter int SET_WORDS = 8,
    parameter int ACC_WORDS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          xfer_start,
    input  logic          xfer_done,
    input  logic          sw_switch,
    input  logic          pat_hit,
    input  logic [DW-1:0] crc_in,
    input  logic          ll_valid,
    input  logic [DW-1:0] ll_word,
    input  logic          err_clr,
    output logic [DW-1:0] src_addr,
    output logic [DW-1:0] dst_addr,
    output logic [DW-1:0] shd_addr,
    output logic [DW-1:0] sum_reg,
    output logic          ll_req,
    output logic [DW-1:0] ll_ptr,
    output logic          pend,
    output logic          err
);

    mode_dec_t     dec;
    logic          last, commit;
    logic [DW-1:0] stg_src, stg_dst, stg_shd, stg_sum;

    assign dec = decode_mode(mode);

    dsh_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ll_mode   (dec.ll),
        .safe_mode (dec.ll_safe),
        .cond_mode (dec.ll_cond),
        .done      (xfer_done),
        .pat_hit   (pat_hit),
        .shd       (shd_addr),
        .sum       (sum_reg),
        .stg_sum   (stg_sum),
        .crc_in    (crc_in),
        .last      (last),
        .err_clr   (err_clr),
        .ll_req    (ll_req),
        .ll_ptr    (ll_ptr),
        .commit    (commit),
        .err       (err)
    );

    dsh_ll_stage #(.DW(DW), .SET_WORDS(SET_WORDS), .ACC_WORDS(ACC_WORDS)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetching (ll_req),
        .acc_mode (dec.ll_acc),
        .ll_valid (ll_valid),
        .ll_word  (ll_word),
        .last     (last),
        .stg_src  (stg_src),
        .stg_dst  (stg_dst),
        .stg_shd  (stg_shd),
        .stg_sum  (stg_sum)
    );

    dsh_addr_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .direct   (dec.direct),
        .src_buf  (dec.src_buf),
        .dst_buf  (dec.dst_buf),
        .src_dbl  (dec.src_dbl),
        .dst_dbl  (dec.dst_dbl),
        .hw_sw    (dec.hw_sw),
        .keep_sum (dec.ll_acc),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .start    (xfer_start),
        .done     (xfer_done),
        .sw       (sw_switch),
        .commit   (commit),
        .stg_src  (stg_src),
        .stg_dst  (stg_dst),
        .stg_shd  (stg_shd),
        .stg_sum  (stg_sum),
        .src_q    (src_addr),
        .dst_q    (dst_addr),
        .shd_q    (shd_addr),
        .sum_q    (sum_reg),
        .pend_q   (pend)
    );

endmodule

// File: tb/sim_dma_shadow_ctl.sv
`timescale 1ns/1ps
module sim_dma_shadow_ctl;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    mode;
    logic          wr_en;
    logic [1:0]    wr_sel;
    logic [DW-1:0] wr_data;
    logic          xfer_start, xfer_done, sw_switch, pat_hit;
    logic [DW-1:0] crc_in;
    logic          ll_valid;
    logic [DW-1:0] ll_word;
    logic          err_clr;
    logic [DW-1:0] src_addr, dst_addr, shd_addr, sum_reg, ll_ptr;
    logic          ll_req, pend, err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_shadow_ctl #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .sw_switch(sw_switch), .pat_hit(pat_hit), .crc_in(crc_in),
        .ll_valid(ll_valid), .ll_word(ll_word), .err_clr(err_clr),
        .src_addr(src_addr), .dst_addr(dst_addr), .shd_addr(shd_addr),
        .sum_reg(sum_reg), .ll_req(ll_req), .ll_ptr(ll_ptr), .pend(pend), .err(err)
    );

    typedef struct packed {
        logic [3:0]  md;
        logic        we;
        logic [1:0]  sel;
        logic [31:0] d;
        logic        st;
        logic        dn;
        logic        sw;
        logic [31:0] es;
        logic [31:0] ed;
        logic [31:0] eh;
        logic        ep;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{4'd0,  1'b1, 2'd0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h100, 32'h0,   32'h0,   1'b0, 4'd1}, // R1
        '{4'd0,  1'b1, 2'd1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h100, 32'h200, 32'h0,   1'b0, 4'd1}, // R1
        '{4'd13, 1'b1, 2'd0, 32'h110, 1'b0, 1'b0, 1'b0, 32'h110, 32'h200, 32'h0,   1'b0, 4'd1}, // R1 out-of-range
        '{4'd1,  1'b1, 2'd0, 32'h300, 1'b0, 1'b0, 1'b0, 32'h110, 32'h200, 32'h300, 1'b1, 4'd2}, // R2
        '{4'd1,  1'b0, 2'd0, 32'h0,   1'b0, 1'b0, 1'b0, 32'h110, 32'h200, 32'h300, 1'b1, 4'd2}, // R2 hold
        '{4'd1,  1'b1, 2'd0, 32'h310, 1'b0, 1'b0, 1'b0, 32'h110, 32'h200, 32'h310, 1'b1, 4'd4}, // R4 replace
        '{4'd1,  1'b0, 2'd0, 32'h0,   1'b1, 1'b0, 1'b0, 32'h310, 32'h200, 32'h310, 1'b0, 4'd2}, // R2 start
        '{4'd3,  1'b1, 2'd0, 32'h320, 1'b1, 1'b0, 1'b0, 32'h310, 32'h200, 32'h320, 1'b1, 4'd4}, // R4 write+start
        '{4'd3,  1'b0, 2'd0, 32'h0,   1'b1, 1'b0, 1'b0, 32'h320, 32'h200, 32'h320, 1'b0, 4'd2}, // R2
        '{4'd2,  1'b1, 2'd1, 32'h400, 1'b0, 1'b0, 1'b0, 32'h320, 32'h200, 32'h400, 1'b1, 4'd3}, // R3
        '{4'd4,  1'b0, 2'd0, 32'h0,   1'b1, 1'b0, 1'b0, 32'h320, 32'h400, 32'h400, 1'b0, 4'd3}, // R3 start
        '{4'd2,  1'b1, 2'd0, 32'h330, 1'b0, 1'b0, 1'b0, 32'h330, 32'h400, 32'h400, 1'b0, 4'd3}, // R3 src direct
        '{4'd5,  1'b1, 2'd2, 32'h500, 1'b0, 1'b0, 1'b0, 32'h330, 32'h400, 32'h500, 1'b0, 4'd5}, // R5
        '{4'd5,  1'b0, 2'd0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h500, 32'h400, 32'h330, 1'b0, 4'd5}, // R5 sw swap
        '{4'd5,  1'b0, 2'd0, 32'h0,   1'b0, 1'b1, 1'b0, 32'h500, 32'h400, 32'h330, 1'b0, 4'd5}, // R5 done ignored
        '{4'd6,  1'b0, 2'd0, 32'h0,   1'b0, 1'b1, 1'b0, 32'h330, 32'h400, 32'h500, 1'b0, 4'd6}, // R6 hw swap
        '{4'd6,  1'b0, 2'd0, 32'h0,   1'b0, 1'b1, 1'b1, 32'h500, 32'h400, 32'h330, 1'b0, 4'd6}, // R6 single swap
        '{4'd7,  1'b0, 2'd0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h500, 32'h330, 32'h400, 1'b0, 4'd5}, // R5 dst
        '{4'd8,  1'b0, 2'd0, 32'h0,   1'b0, 1'b1, 1'b0, 32'h500, 32'h400, 32'h330, 1'b0, 4'd6}, // R6 dst
        '{4'd1,  1'b0, 2'd0, 32'h0,   1'b1, 1'b0, 1'b0, 32'h500, 32'h400, 32'h330, 1'b0, 4'd2}  // R2 no pend
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
        xfer_start = 1'b0; xfer_done = 1'b0; sw_switch = 1'b0;
        ll_valid = 1'b0; ll_word = '0; err_clr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse_done;
        xfer_done = 1'b1;
        cyc();
        xfer_done = 1'b0;
    endtask

    task automatic stream(input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                          input logic [DW-1:0] w2, input logic [DW-1:0] w6, input int n);
        for (int k = 0; k < n; k++) begin
            ll_valid = 1'b1;
            ll_word  = (k == 0) ? w0 : (k == 1) ? w1 : (k == 2) ? w2 :
                       (k == 6) ? w6 : 32'hEE00_0000 + k;
            cyc();
        end
        ll_valid = 1'b0;
        ll_word  = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = 4'd0; pat_hit = 1'b0; crc_in = '0;
        idle_inputs();
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R12 reset state
        chk("R12 src", src_addr, 0);
        chk("R12 dst", dst_addr, 0);
        chk("R12 shd", shd_addr, 0);
        chk("R12 sum", sum_reg, 0);
        chk("R12 req", {31'b0, ll_req}, 0);
        chk("R12 pend", {31'b0, pend}, 0);
        chk("R12 err", {31'b0, err}, 0);

        // register-mode vectors, one cycle each
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = TBL[i];
            automatic string tag = $sformatf("R%0d row%0d", v.rq, i);
            mode = v.md; wr_en = v.we; wr_sel = v.sel; wr_data = v.d;
            xfer_start = v.st; xfer_done = v.dn; sw_switch = v.sw;
            cyc();
            idle_inputs();
            chk({tag, " src"}, src_addr, v.es);
            chk({tag, " dst"}, dst_addr, v.ed);
            chk({tag, " shd"}, shd_addr, v.eh);
            chk({tag, " pend"}, {31'b0, pend}, {31'b0, v.ep});
        end

        // linked-list setup
        mode = 4'd0;
        wr(2'd2, 32'h1000);
        wr(2'd3, 32'h77);

        // R7 / R8 plain linked list
        mode = 4'd9;
        pulse_done();
        chk("R7 req", {31'b0, ll_req}, 1);
        chk("R7 ptr", ll_ptr, 32'h1000);
        wr(2'd2, 32'h1111);           // shadow changes during fetch
        pulse_done();                 // R13 done during fetch
        chk("R13 ptr hold", ll_ptr, 32'h1000);
        chk("R13 req hold", {31'b0, ll_req}, 1);
        stream(32'hA000, 32'hB000, 32'h2000, 32'hC5C5, 8);
        chk("R7 req low", {31'b0, ll_req}, 0);
        cyc();
        chk("R8 src", src_addr, 32'hA000);
        chk("R8 dst", dst_addr, 32'hB000);
        chk("R8 shd", shd_addr, 32'h2000);
        chk("R8 sum", sum_reg, 32'hC5C5);

        // R9 accumulated: 6 words, checksum kept
        mode = 4'd10;
        pulse_done();
        chk("R9 ptr", ll_ptr, 32'h2000);
        stream(32'hA100, 32'hB100, 32'h2100, 32'h0, 6);
        chk("R9 req low", {31'b0, ll_req}, 0);
        cyc();
        chk("R9 src", src_addr, 32'hA100);
        chk("R9 dst", dst_addr, 32'hB100);
        chk("R9 shd", shd_addr, 32'h2100);
        chk("R9 sum kept", sum_reg, 32'hC5C5);

        // R10 guarded, match
        mode = 4'd11;
        crc_in = 32'h1234;
        pulse_done();
        stream(32'hA200, 32'hB200, 32'h2200, 32'h1234, 8);
        cyc();
        chk("R10 match src", src_addr, 32'hA200);
        chk("R10 match sum", sum_reg, 32'h1234);
        chk("R10 match err", {31'b0, err}, 0);

        // R10 guarded, mismatch
        pulse_done();
        stream(32'hA300, 32'hB300, 32'h2300, 32'h9999, 8);
        cyc();
        chk("R10 err set", {31'b0, err}, 1);
        chk("R10 no commit", src_addr, 32'hA200);
        pulse_done();                 // R13 done while halted
        chk("R13 halt no req", {31'b0, ll_req}, 0);
        chk("R10 err sticky", {31'b0, err}, 1);
        err_clr = 1'b1;
        cyc();
        err_clr = 1'b0;
        chk("R10 err cleared", {31'b0, err}, 0);

        // R11 conditional pointer select
        mode = 4'd12;
        pat_hit = 1'b1;
        pulse_done();
        pat_hit = 1'b0;
        chk("R11 ptr sum", ll_ptr, 32'h1234);
        stream(32'hA400, 32'hB400, 32'h2400, 32'h5555, 8);
        cyc();
        chk("R11 sum", sum_reg, 32'h5555);
        pulse_done();
        chk("R11 ptr shd", ll_ptr, 32'h2400);
        stream(32'hA500, 32'hB500, 32'h2500, 32'h6666, 8);
        cyc();
        chk("R11 src", src_addr, 32'hA500);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule